// File: doc/BRIEF.md
# Dead-Battery Boot Strap Sequencer

This block runs the power-on boot flow of a USB power-delivery port controller. On the first clock after reset it captures a one-bit strap level and an 8-bit code that gives a resistor-divider ratio as a fraction of full scale (code / 255). From the pair it derives two independent policies. The first is a dead-battery mode, which decides whether a sink switch may close before firmware exists and whether the 3.3-V rail must be present before loading starts. The second is a default configuration, which is used when a configuration load fails.

After the capture the block steps through its flow. It drives the internal or the external sink-path enable as the mode allows, and it issues one-cycle load requests to an external loader. Each request is answered by a done or a fail pulse. When the answer is fail and the default is the endless-wait policy, the block retries after a programmable gap. When the flow ends it reports boot completion and whether the default was used.

Top module: `boot_strap_seq`

## Requirements
- R1: With `strap_lvl`=1 the ratio percentage p = floor(div_code*100/255) decodes as follows. p 0..18 gives no-response mode. 20..28 gives wait-for-3.3V with the internal switch. 30..38 gives endless-retry with the internal switch. 40..48 gives wait-for-3.3V with the external switch. 50..58 gives endless-retry with the external switch. 60..100 gives load-without-waiting. The endless-retry bands report `cfg_sel`=1 (endless wait); every other band reports `cfg_sel`=0 (safe).
- R2: With `strap_lvl`=0 the decode is as follows. p 10..18 gives no-response with `cfg_sel`=2. 20..28 gives load-without-waiting with 3. 30..38 gives endless-retry internal with 1. 40..48 gives load-without-waiting with 4. 50..58 gives endless-retry external with 1. 60..68 gives load-without-waiting with 5. 70..78 gives load-without-waiting with 7 (reserved). 80..88 gives no-response with 7. 90..100 gives load-without-waiting with 6.
- R3: A percentage in a gap between bands (units digit 9, outside the top band), and with `strap_lvl`=0 any p below 10, decodes to no-response mode with `cfg_sel`=0.
- R4: Strap and code are captured only on the first clock after reset release. Later changes leave `cfg_sel` and the flow unchanged.
- R5: In no-response mode neither sink enable is high before completion, and no request is made until `v3p3_ok` is seen high.
- R6: In the wait-for-3.3V modes the selected sink enable is high from the first clock after reset. The first `load_req` comes one clock after the edge that samples `v3p3_ok` high.
- R7: In the endless-retry and load-without-waiting modes `load_req` is high right after the capture edge, whatever `v3p3_ok` is. Load-without-waiting keeps both sink enables low until a load completes.
- R8: `load_req` is high for exactly one cycle. `load_done` and `load_fail` are ignored unless a request is outstanding.
- R9: Under the endless-wait default a sampled `load_fail` leads to the next `load_req` `retry_gap`+1 clocks after the sampling edge, and `boot_done` stays low.
- R10: A sampled `load_done` sets `boot_done`, which then stays high. `cfg_path` bit 0 then drives the internal sink and bit 1 the external sink, and `fallback_act` stays 0. `load_done` wins over a simultaneous `load_fail`.
- R11: A sampled `load_fail` under any other default sets `boot_done` and `fallback_act`. The sink path then follows the default: `cfg_sel` 3 or 4 selects internal, 5 or 6 selects external, and all others select none.
- R12: Sink enables are low whenever `vbus_ok` is low. In reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_lvl | input | 1 | Digital strap level |
| div_code | input | 8 | Divider ratio code, full scale 255 |
| v3p3_ok | input | 1 | 3.3-V rail present |
| vbus_ok | input | 1 | VBUS present |
| load_done | input | 1 | Configuration load succeeded (pulse) |
| load_fail | input | 1 | Configuration load failed (pulse) |
| cfg_path | input | 2 | Sink path chosen by the loaded configuration, valid with load_done |
| retry_gap | input | 8 | Idle clocks between a failed load and a retry, minus one |
| int_sink_en | output | 1 | Internal high-voltage sink switch enable |
| ext_sink_en | output | 1 | External sink-path control enable |
| load_req | output | 1 | Configuration load request strobe |
| cfg_sel | output | 3 | Decoded default configuration code |
| fallback_act | output | 1 | Boot ended on the default configuration |
| boot_done | output | 1 | Boot flow finished |

## Verification
The decoded default and the dead-battery sink enable are registered on the capture edge, so they are due right after the first clock following reset release. In modes that load at once the first request is also due at that edge. A request that waits on the rail comes one edge after `v3p3_ok` is sampled. Completion and fallback outputs change on the edge that samples the answer pulse. A retry comes `retry_gap`+1 edges after the failing edge, and the bench counts edges to catch a request that is one early or one late. Inputs change and outputs are read on the falling edge, so every read falls between the registering edges named above.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    DB_NORESP   = 3'd0,
    DB_WAIT_INT = 3'd1,
    DB_WAIT_EXT = 3'd2,
    DB_ECW_INT  = 3'd3,
    DB_ECW_EXT  = 3'd4,
    DB_NOWAIT   = 3'd5
  } db_mode_e;

  typedef enum logic [2:0] {
    FB_SAFE = 3'd0,
    FB_INF  = 3'd1,
    FB_C1   = 3'd2,
    FB_C2   = 3'd3,
    FB_C3   = 3'd4,
    FB_C4   = 3'd5,
    FB_C5   = 3'd6,
    FB_RSVD = 3'd7
  } fb_cfg_e;

  typedef struct packed {
    db_mode_e mode;
    fb_cfg_e  fb;
  } strap_dec_t;

  // sink path bits: [0] internal switch, [1] external path
  function automatic logic [1:0] mode_db_path(input db_mode_e m);
    case (m)
      DB_WAIT_INT, DB_ECW_INT: return 2'b01;
      DB_WAIT_EXT, DB_ECW_EXT: return 2'b10;
      default:                 return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] fb_path(input fb_cfg_e f);
    case (f)
      FB_C2, FB_C3: return 2'b01;
      FB_C4, FB_C5: return 2'b10;
      default:      return 2'b00;
    endcase
  endfunction

  // modes that stall until the 3.3-V rail is up
  function automatic logic mode_needs_rail(input db_mode_e m);
    return (m == DB_NORESP) || (m == DB_WAIT_INT) || (m == DB_WAIT_EXT);
  endfunction

endpackage

// File: rtl/strap_decode.sv
module strap_decode
  import boot_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              strap,
  input  logic [CODE_W-1:0] code,
  output strap_dec_t        dec
);
  localparam int FULL = (1 << CODE_W) - 1;
  localparam int PW   = CODE_W + 8;

  function automatic logic [6:0] to_pct(input logic [CODE_W-1:0] c);
    logic [PW-1:0] prod;
    prod = PW'(c) * PW'(100);
    return 7'(prod / PW'(FULL));
  endfunction

  logic [6:0] pct;
  logic [3:0] tens, units, band;

  always_comb begin
    pct   = to_pct(code);
    tens  = 4'(pct / 7'd10);
    units = 4'(pct % 7'd10);
    band  = (tens == 4'd10) ? 4'd9 : tens;
    dec.mode = DB_NORESP;
    dec.fb   = FB_SAFE;
    if (strap) begin
      if (tens >= 4'd6) begin
        dec.mode = DB_NOWAIT;
      end else if (units != 4'd9) begin
        case (tens)
          4'd2: dec.mode = DB_WAIT_INT;
          4'd3: begin dec.mode = DB_ECW_INT; dec.fb = FB_INF; end
          4'd4: dec.mode = DB_WAIT_EXT;
          4'd5: begin dec.mode = DB_ECW_EXT; dec.fb = FB_INF; end
          default: ;
        endcase
      end
    end else if (band != 4'd0 && (units != 4'd9 || band == 4'd9)) begin
      case (band)
        4'd1: begin dec.mode = DB_NORESP;  dec.fb = FB_C1;   end
        4'd2: begin dec.mode = DB_NOWAIT;  dec.fb = FB_C2;   end
        4'd3: begin dec.mode = DB_ECW_INT; dec.fb = FB_INF;  end
        4'd4: begin dec.mode = DB_NOWAIT;  dec.fb = FB_C3;   end
        4'd5: begin dec.mode = DB_ECW_EXT; dec.fb = FB_INF;  end
        4'd6: begin dec.mode = DB_NOWAIT;  dec.fb = FB_C4;   end
        4'd7: begin dec.mode = DB_NOWAIT;  dec.fb = FB_RSVD; end
        4'd8: begin dec.mode = DB_NORESP;  dec.fb = FB_RSVD; end
        default: begin dec.mode = DB_NOWAIT; dec.fb = FB_C5; end
      endcase
    end
  end
endmodule

// File: rtl/retry_timer.sv
module retry_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] gap,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= gap;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R9: the gap shrinks by one per clock once loaded
  assert_gap_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/boot_strap_seq.sv
module boot_strap_seq
  import boot_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_lvl,
  input  logic [CODE_W-1:0] div_code,
  input  logic              v3p3_ok,
  input  logic              vbus_ok,
  input  logic              load_done,
  input  logic              load_fail,
  input  logic [1:0]        cfg_path,
  input  logic [GAP_W-1:0]  retry_gap,
  output logic              int_sink_en,
  output logic              ext_sink_en,
  output logic              load_req,
  output logic [2:0]        cfg_sel,
  output logic              fallback_act,
  output logic              boot_done
);
  typedef enum logic [2:0] {
    ST_SAMPLE, ST_HOLD, ST_REQ, ST_WAIT, ST_GAP, ST_DONE
  } seq_st_e;

  seq_st_e    st_q;
  db_mode_e   mode_q;
  fb_cfg_e    fb_q;
  logic [1:0] path_q;
  logic       fb_act_q;
  strap_dec_t dec;

  // named internal events
  logic ev_latch, ev_accept, ev_reject, ev_retry, gap_expired;

  strap_decode #(.CODE_W(CODE_W)) u_dec (
    .strap (strap_lvl),
    .code  (div_code),
    .dec   (dec)
  );

  assign ev_latch  = (st_q == ST_SAMPLE);
  assign ev_accept = (st_q == ST_WAIT) && load_done;
  assign ev_reject = (st_q == ST_WAIT) && !load_done && load_fail;
  assign ev_retry  = ev_reject && (fb_q == FB_INF);

  retry_timer #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ev_retry),
    .gap     (retry_gap),
    .expired (gap_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_SAMPLE;
      mode_q   <= DB_NORESP;
      fb_q     <= FB_SAFE;
      path_q   <= 2'b00;
      fb_act_q <= 1'b0;
    end else begin
      case (st_q)
        ST_SAMPLE: begin
          mode_q <= dec.mode;
          fb_q   <= dec.fb;
          path_q <= mode_db_path(dec.mode);
          st_q   <= mode_needs_rail(dec.mode) ? ST_HOLD : ST_REQ;
        end
        ST_HOLD: if (v3p3_ok) st_q <= ST_REQ;
        ST_REQ:  st_q <= ST_WAIT;
        ST_WAIT: begin
          if (ev_accept) begin
            path_q <= cfg_path;
            st_q   <= ST_DONE;
          end else if (ev_retry) begin
            st_q   <= ST_GAP;
          end else if (ev_reject) begin
            path_q   <= fb_path(fb_q);
            fb_act_q <= 1'b1;
            st_q     <= ST_DONE;
          end
        end
        ST_GAP:  if (gap_expired) st_q <= ST_REQ;
        ST_DONE: st_q <= ST_DONE;
        default: st_q <= ST_SAMPLE;
      endcase
    end
  end

  assign int_sink_en  = path_q[0] & vbus_ok;
  assign ext_sink_en  = path_q[1] & vbus_ok;
  assign load_req     = (st_q == ST_REQ);
  assign cfg_sel      = fb_q;
  assign fallback_act = fb_act_q;
  assign boot_done    = (st_q == ST_DONE);

  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_latch |=> $stable(cfg_sel));

  assert_noresp_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_done && mode_q == DB_NORESP) |-> !(int_sink_en || ext_sink_en));

  assert_rail_before_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && mode_needs_rail(mode_q)) |-> $past(v3p3_ok));

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !load_req);

  assert_inf_no_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q == FB_INF) |-> !fallback_act);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  assert_fallback_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_act |-> boot_done);

  assert_vbus_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sink_en || ext_sink_en) |-> vbus_ok);
endmodule

// File: tb/sim_boot_strap_seq.sv
module sim_boot_strap_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_lvl = 1'b0;
  logic [7:0] div_code = '0;
  logic       v3p3_ok = 1'b0, vbus_ok = 1'b1, load_done = 1'b0, load_fail = 1'b0;
  logic [1:0] cfg_path = '0;
  logic [7:0] retry_gap = 8'd3;
  logic       int_sink_en, ext_sink_en, load_req, fallback_act, boot_done;
  logic [2:0] cfg_sel;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  boot_strap_seq u0 (
    .clk(clk), .rst_n(rst_n), .strap_lvl(strap_lvl), .div_code(div_code),
    .v3p3_ok(v3p3_ok), .vbus_ok(vbus_ok), .load_done(load_done), .load_fail(load_fail),
    .cfg_path(cfg_path), .retry_gap(retry_gap), .int_sink_en(int_sink_en),
    .ext_sink_en(ext_sink_en), .load_req(load_req), .cfg_sel(cfg_sel),
    .fallback_act(fallback_act), .boot_done(boot_done)
  );

  // {strap, code, expected cfg_sel, expected {ext,int}, request right after capture}
  localparam logic [14:0] VEC [24] = '{
    {1'b1, 8'd20,  3'd0, 2'd0, 1'b0}, {1'b1, 8'd48,  3'd0, 2'd0, 1'b0},
    {1'b1, 8'd49,  3'd0, 2'd0, 1'b0}, {1'b1, 8'd60,  3'd0, 2'd1, 1'b0},
    {1'b1, 8'd76,  3'd0, 2'd0, 1'b0}, {1'b1, 8'd90,  3'd1, 2'd1, 1'b1},
    {1'b1, 8'd115, 3'd0, 2'd2, 1'b0}, {1'b1, 8'd140, 3'd1, 2'd2, 1'b1},
    {1'b1, 8'd200, 3'd0, 2'd0, 1'b1}, {1'b1, 8'd255, 3'd0, 2'd0, 1'b1},
    {1'b0, 8'd10,  3'd0, 2'd0, 1'b0}, {1'b0, 8'd25,  3'd0, 2'd0, 1'b0},
    {1'b0, 8'd26,  3'd2, 2'd0, 1'b0}, {1'b0, 8'd30,  3'd2, 2'd0, 1'b0},
    {1'b0, 8'd60,  3'd3, 2'd0, 1'b1}, {1'b0, 8'd90,  3'd1, 2'd1, 1'b1},
    {1'b0, 8'd100, 3'd0, 2'd0, 1'b0}, {1'b0, 8'd115, 3'd4, 2'd0, 1'b1},
    {1'b0, 8'd140, 3'd1, 2'd2, 1'b1}, {1'b0, 8'd165, 3'd5, 2'd0, 1'b1},
    {1'b0, 8'd190, 3'd7, 2'd0, 1'b1}, {1'b0, 8'd215, 3'd7, 2'd0, 1'b0},
    {1'b0, 8'd240, 3'd6, 2'd0, 1'b1}, {1'b0, 8'd255, 3'd6, 2'd0, 1'b1}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reset with the given strap, release, and pass the capture edge
  task automatic boot(input logic s, input logic [7:0] c);
    rst_n = 1'b0; strap_lvl = s; div_code = c; v3p3_ok = 1'b0; vbus_ok = 1'b1;
    load_done = 1'b0; load_fail = 1'b0; cfg_path = 2'b00;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R12: reset state
    rst_n = 1'b0; strap_lvl = 1'b1; div_code = 8'd90; tick(); tick();
    chk("R12 reset outputs", {int_sink_en, ext_sink_en, load_req, cfg_sel, fallback_act, boot_done}, 0);

    // R1 R2 R3 R6 R7 decode table
    for (int i = 0; i < 24; i++) begin
      logic [14:0] v;
      v = VEC[i];
      boot(v[14], v[13:6]);
      chk(v[14] ? "R1/R3 cfg_sel" : "R2/R3 cfg_sel", cfg_sel, v[5:3]);
      chk("R6/R7 sink path", {ext_sink_en, int_sink_en}, v[2:1]);
      chk("R7 early request", load_req, v[0]);
    end

    // R6 R8 R10: wait-for-rail internal, then load selecting external
    boot(1'b1, 8'd60);
    load_done = 1'b1; tick(); load_done = 1'b0;
    chk("R8 stray done ignored", boot_done, 0);
    strap_lvl = 1'b0; div_code = 8'd165; tick(); tick();
    chk("R4 cfg frozen", cfg_sel, 0);
    chk("R6 no request before rail", load_req, 0);
    chk("R4 path frozen", {ext_sink_en, int_sink_en}, 1);
    vbus_ok = 1'b0; #1;
    chk("R12 vbus gate", int_sink_en, 0);
    vbus_ok = 1'b1;
    v3p3_ok = 1'b1; tick();
    chk("R6 request after rail", load_req, 1);
    tick();
    chk("R8 single pulse", load_req, 0);
    load_done = 1'b1; load_fail = 1'b1; cfg_path = 2'b10; tick();
    load_done = 1'b0; load_fail = 1'b0;
    chk("R10 done", boot_done, 1);
    chk("R10 loaded path", {ext_sink_en, int_sink_en}, 2);
    chk("R10 done wins", fallback_act, 0);
    load_fail = 1'b1; tick(); load_fail = 1'b0; tick();
    chk("R10 sticky", {boot_done, fallback_act}, 2);

    // R5: no-response waits for rail with switches open
    boot(1'b0, 8'd30);
    repeat (5) tick();
    chk("R5 halted", {load_req, int_sink_en, ext_sink_en}, 0);
    v3p3_ok = 1'b1; tick();
    chk("R5 request after rail", load_req, 1);

    // R9: endless retry with gap 3
    retry_gap = 8'd3;
    boot(1'b1, 8'd90);
    chk("R9 first request", load_req, 1);
    for (int r = 0; r < 2; r++) begin
      tick();
      load_fail = 1'b1; tick(); load_fail = 1'b0;
      tick(); tick(); tick();
      chk("R9 not early", load_req, 0);
      tick();
      chk("R9 retry due", load_req, 1);
      chk("R9 not done", boot_done, 0);
    end
    retry_gap = 8'd0;
    tick(); load_fail = 1'b1; tick(); load_fail = 1'b0; tick();
    chk("R9 zero gap retry", load_req, 1);
    tick(); load_done = 1'b1; cfg_path = 2'b01; tick(); load_done = 1'b0;
    chk("R10 done after retries", {boot_done, int_sink_en, fallback_act}, 6);

    // R11: fallbacks
    boot(1'b0, 8'd165);
    tick(); load_fail = 1'b1; tick(); load_fail = 1'b0;
    chk("R11 cfg4 fallback", {boot_done, fallback_act, ext_sink_en, int_sink_en}, 4'b1110);
    boot(1'b0, 8'd60);
    tick(); load_fail = 1'b1; tick(); load_fail = 1'b0;
    chk("R11 cfg2 fallback", {boot_done, fallback_act, ext_sink_en, int_sink_en}, 4'b1101);
    boot(1'b1, 8'd200);
    tick(); load_fail = 1'b1; tick(); load_fail = 1'b0;
    chk("R11 safe fallback", {boot_done, fallback_act, ext_sink_en, int_sink_en}, 4'b1100);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule